// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block controls one port of up to sixteen general-purpose pins for a microcontroller subsystem. A small synchronous register bus reads and writes four registers. The direction register picks input or output for each pin. The output latch holds the value that output pins drive. The port address returns the pin levels after synchronization. The analog-select register blanks the digital input of pins that are used as analog channels. The block drives one output-enable and one output-data signal per pin toward the pad ring, and it samples one input level per pin from the pad.

Each instance is sized by two masks. The implemented mask gives the bit positions that exist on this port. Every other position is inert: it drives nothing, reads as zero and ignores writes. The analog-capable mask gives the positions that may be switched to analog use. After reset every implemented pin is an input. Analog-capable pins come out of reset in analog mode.

Reads of the latch and reads of the port are separate paths. Software can therefore tell the value it intends to drive apart from the level the pin actually shows. A write to the port address is stored in the latch, in the same way as a write to the latch address.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the direction register reads the implemented mask (all pins inputs), the latch reads 0, the analog-select register reads the analog-capable mask ANDed with the implemented mask, and pad_oe is 0.
- R2: A direction bit of 1 makes the pin an input (pad_oe bit 0, pad_out bit 0). A direction bit of 0 makes it an output (pad_oe bit 1, pad_out bit equal to the latch bit).
- R3: A read at address 1 (latch) returns the stored latch contents, whatever level the pins show.
- R4: A read at address 2 (port) returns pad_in after a two-flop synchronizer. A pad change made between two clock edges is visible after the second following rising edge and not after the first.
- R5: A write to address 2 (port) updates the latch exactly as a write to address 1 does, and leaves the direction register unchanged.
- R6: Bit positions outside the implemented mask read as 0 in every register and in the port value, ignore writes, and never assert pad_oe or pad_out.
- R7: A pin whose analog-select bit (address 3) is 1 reads 0 through the port address. Writes to the analog-select register take effect only in analog-capable implemented positions.
- R8: Address encoding: 0 = direction, 1 = latch, 2 = port, 3 = analog select. A write with bus_we high takes effect at the next rising clock edge. bus_rdata follows bus_addr combinationally. With bus_we low no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select (0 direction, 1 latch, 2 port, 3 analog select) |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the addressed register |
| pad_in | input | WIDTH | Asynchronous pin levels from the pads |
| pad_oe | output | WIDTH | Per-pin output enable, 1 = drive |
| pad_out | output | WIDTH | Per-pin output data |

## Verification
Two functions can fall in the same cycle: a write to the port address and a change of the pad levels. The write lands in the latch, while the port read path carries the synchronized pad levels. The bench drives both on the same half-cycle with different values. It then reads the latch and expects the written value at once. It reads the port and expects the new pad levels only after two rising edges, never the value just written. A second same-cycle case is a combinational read of a register during the cycle in which it is written. That read must still return the old contents until the edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_ANA  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int               WIDTH   = 16,
  parameter logic [WIDTH-1:0] KEEP    = '1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [WIDTH-1:0] wd,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] RST_KEPT = RST_VAL & KEEP;

  function automatic logic [WIDTH-1:0] keep_bits(input logic [WIDTH-1:0] d);
    return d & KEEP;
  endfunction

  logic [WIDTH-1:0] nxt;
  assign nxt = we ? keep_bits(wd) : q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (KEEP[b]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q[b] <= RST_KEPT[b];
        else        q[b] <= nxt[b];
      end
    end else begin : g_dead
      assign q[b] = 1'b0;
    end
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int               WIDTH = 16,
  parameter logic [WIDTH-1:0] IMPL  = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] ana_sel,
  output logic [WIDTH-1:0] pin_level
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  function automatic logic [WIDTH-1:0] digital_view(input logic [WIDTH-1:0] lvl,
                                                     input logic [WIDTH-1:0] ana);
    return lvl & ~ana & IMPL;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in & IMPL;
      sync_q <= meta_q;
    end
  end

  assign pin_level = digital_view(sync_q, ana_sel);

  logic [1:0] settle_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_cnt <= '0;
    else if (settle_cnt != 2'd2) settle_cnt <= settle_cnt + 2'd1;
  end

  // R4
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_cnt == 2'd2) |-> (sync_q == ($past(pad_in, 2) & IMPL)));

  // R7
  analog_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_level & ana_sel) == '0);
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int                 WIDTH     = 16,
  parameter logic [WIDTH-1:0]   IMPL_MASK = '1,
  parameter logic [WIDTH-1:0]   ANA_MASK  = 16'h000F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [gpio_pkg::SEL_W-1:0] bus_addr,
  input  logic                      bus_we,
  input  logic [WIDTH-1:0]          bus_wdata,
  output logic [WIDTH-1:0]          bus_rdata,
  input  logic [WIDTH-1:0]          pad_in,
  output logic [WIDTH-1:0]          pad_oe,
  output logic [WIDTH-1:0]          pad_out
);
  import gpio_pkg::*;

  localparam logic [WIDTH-1:0] ANA_KEEP = ANA_MASK & IMPL_MASK;

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  logic wr_dir, wr_lat, wr_ana;
  assign wr_dir = bus_we && (sel == SEL_DIR);
  assign wr_lat = bus_we && ((sel == SEL_LAT) || (sel == SEL_PIN));
  assign wr_ana = bus_we && (sel == SEL_ANA);

  logic [WIDTH-1:0] dir_q, lat_q, ana_q, pin_level;

  gpio_cfg_reg #(.WIDTH(WIDTH), .KEEP(IMPL_MASK), .RST_VAL(IMPL_MASK)) u_dir (
    .clk(clk), .rst_n(rst_n), .we(wr_dir), .wd(bus_wdata), .q(dir_q));

  gpio_cfg_reg #(.WIDTH(WIDTH), .KEEP(IMPL_MASK), .RST_VAL('0)) u_lat (
    .clk(clk), .rst_n(rst_n), .we(wr_lat), .wd(bus_wdata), .q(lat_q));

  gpio_cfg_reg #(.WIDTH(WIDTH), .KEEP(ANA_KEEP), .RST_VAL(ANA_KEEP)) u_ana (
    .clk(clk), .rst_n(rst_n), .we(wr_ana), .wd(bus_wdata), .q(ana_q));

  gpio_in_sync #(.WIDTH(WIDTH), .IMPL(IMPL_MASK)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .ana_sel(ana_q),
    .pin_level(pin_level));

  function automatic logic [WIDTH-1:0] drive_enable(input logic [WIDTH-1:0] dir);
    return ~dir & IMPL_MASK;
  endfunction

  assign pad_oe  = drive_enable(dir_q);
  assign pad_out = lat_q & pad_oe;

  always_comb begin
    unique case (sel)
      SEL_DIR: bus_rdata = dir_q;
      SEL_LAT: bus_rdata = lat_q;
      SEL_PIN: bus_rdata = pin_level;
      SEL_ANA: bus_rdata = ana_q;
      default: bus_rdata = '0;
    endcase
  end

  // R2
  drive_only_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0);

  // R2
  quiet_when_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0);

  // R5
  port_write_to_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_PIN) |=> (lat_q == ($past(bus_wdata) & IMPL_MASK)));

  // R5
  port_write_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_PIN) |=> $stable(dir_q));

  // R6
  unimplemented_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata | pad_oe | pad_out) & ~IMPL_MASK) == '0);
endmodule

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;
  localparam int          W    = 16;
  localparam logic [15:0] IMPL = 16'hF3CF;
  localparam logic [15:0] ANA  = 16'h0CC3;
  localparam logic [15:0] ANAK = ANA & IMPL;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   bus_addr = '0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_oe, pad_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_port_bank #(.WIDTH(W), .IMPL_MASK(IMPL), .ANA_MASK(ANA)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(2'd0, v); check("R1 dir reset", v, IMPL);
    rd(2'd1, v); check("R1 lat reset", v, '0);
    rd(2'd3, v); check("R1 ana reset", v, ANAK);
    check("R1 pad_oe reset", pad_oe, '0);
  endtask

  task automatic t_direction();
    wr(2'd1, 16'hA5A5);
    wr(2'd0, 16'h0000);
    #1;
    check("R2 all outputs oe", pad_oe, IMPL);
    check("R2 all outputs data", pad_out, 16'hA5A5 & IMPL);
    wr(2'd0, 16'h00FF);
    #1;
    check("R2 mixed oe", pad_oe, 16'hFF00 & IMPL);
    check("R2 mixed data", pad_out, 16'hA5A5 & 16'hFF00 & IMPL);
  endtask

  task automatic t_latch_vs_pin();
    logic [W-1:0] v;
    @(negedge clk) pad_in = 16'h1234;
    repeat (3) @(negedge clk);
    rd(2'd1, v); check("R3 latch not pins", v, 16'hA5A5 & IMPL);
  endtask

  task automatic t_sync();
    logic [W-1:0] v;
    wr(2'd3, 16'h0000);
    @(negedge clk) pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    bus_addr = 2'd2;
    pad_in = 16'hFFFF;
    @(posedge clk); @(negedge clk); #1;
    check("R4 one edge old", bus_rdata, 16'h0000);
    @(posedge clk); @(negedge clk); #1;
    check("R4 two edges new", bus_rdata, IMPL);
    rd(2'd2, v); check("R4 stays", v, IMPL);
  endtask

  task automatic t_port_write();
    logic [W-1:0] v;
    logic [W-1:0] dir_before;
    rd(2'd0, dir_before);
    @(negedge clk);
    bus_addr = 2'd2; bus_we = 1'b1; bus_wdata = 16'h5A5A; pad_in = 16'h0F0F;
    @(negedge clk);
    bus_we = 1'b0;
    bus_addr = 2'd1; #1;
    check("R5 port write in latch", bus_rdata, 16'h5A5A & IMPL);
    rd(2'd0, v); check("R5 dir untouched", v, dir_before);
    rd(2'd2, v); check("R5 port shows pads", v, 16'h0F0F & IMPL);
  endtask

  task automatic t_unimpl();
    logic [W-1:0] v;
    wr(2'd0, 16'hFFFF); wr(2'd1, 16'hFFFF); wr(2'd3, 16'hFFFF);
    rd(2'd0, v); check("R6 dir unimpl", v & ~IMPL, '0);
    rd(2'd1, v); check("R6 lat unimpl", v & ~IMPL, '0);
    rd(2'd3, v); check("R7 ana capable only", v, ANAK);
    wr(2'd3, 16'h0000);
    @(negedge clk) pad_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    rd(2'd2, v); check("R6 port unimpl", v, IMPL);
    wr(2'd0, 16'h0000);
    #1;
    check("R6 oe unimpl", pad_oe & ~IMPL, '0);
    check("R6 out unimpl", pad_out & ~IMPL, '0);
  endtask

  task automatic t_analog();
    logic [W-1:0] v;
    wr(2'd3, 16'hFFFF);
    rd(2'd2, v); check("R7 analog blanks", v, IMPL & ~ANAK);
    wr(2'd3, 16'h0000);
    rd(2'd2, v); check("R7 analog cleared", v, IMPL);
  endtask

  task automatic t_bus_timing();
    logic [W-1:0] v;
    wr(2'd0, 16'h00F0);
    @(negedge clk);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 16'h0F00; #1;
    check("R8 old before edge", bus_rdata, 16'h00F0 & IMPL);
    @(negedge clk);
    bus_we = 1'b0; #1;
    check("R8 new after edge", bus_rdata, 16'h0F00 & IMPL);
    @(negedge clk);
    bus_wdata = 16'hFFFF; bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R8 idle no write", v, 16'h0F00 & IMPL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_latch_vs_pin();
    t_sync();
    t_port_write();
    t_unimpl();
    t_analog();
    t_bus_timing();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule